// File: doc/BRIEF.md
# Key-Locked Peripheral Configuration Register Unit

This block is a configuration unit that sits behind a pair of adjacent I/O ports. One port is an index port and the next is a data port. A host writes a register number to the index port and then reads or writes that register through the data port. Data-port writes only take effect while the unit is unlocked. Writing a designated key byte to the index port unlocks the unit, and writing a second key byte locks it again.

The registers hold four kinds of setting:
- a function-select byte, which turns individual peripherals on and picks the parallel-port mode;
- base addresses for the floppy, IDE, IDE auxiliary, parallel and two serial devices, each stored with its two lowest address bits dropped;
- nibble-packed IRQ and DMA numbers;
- a floppy drive-swap flag.

The unit decodes these registers into plain per-device outputs: an enable, a 10-bit base address, IRQ and DMA numbers, and the swap flag. Other parts of the chip consume these outputs. The peripherals themselves are outside this block.

Host accesses use a valid/ready request channel. The unit never applies back-pressure: `bus_ready` is high in every cycle after reset, so every request with `bus_valid` high is accepted on that clock edge. A read of either port returns one response, with `rsp_valid` high for exactly one cycle, in the cycle after the request is accepted. The response channel has no ready signal, so the host must take the response in that cycle.

Top module: `cfgx_top`

## Requirements
- R1: After reset the unit is locked and the index is 0x00. The following registers hold their reset values: 0xC0=0x3C, 0xC2=0x03, 0xC3=0x3C, 0xC4=0x3C, 0xC5=0x3D, 0xD5=0x3C. Every other register reads 0x00.
- R2: Writing 0x33 to the index port (0x398) unlocks the unit, and writing 0x55 locks it. In both cases the written byte also becomes the index. While the unit is locked, a data-port (0x399) write changes no register.
- R3: Register 0xC2 stores the written value ANDed with 0xBF. Its bits drive the enables: bit 7 the game port, bit 5 IDE, bit 4 floppy, bit 3 serial 2, bit 2 serial 1.
- R4: Bits 1:0 of 0xC2 appear on `par_mode`, encoded as 00 standard, 01 ECP, 10 EPP, 11 disabled. `en_par` is high only when both bits are 0.
- R5: Each base output equals its register shifted left by two. The registers and their write masks are: floppy 0xC3 (mask 0xFC), IDE 0xC4 (mask 0xFC), parallel 0xC6 (no mask), serial 1 0xC7 (mask 0xFE), serial 2 0xC8 (mask 0xFE).
- R6: A write to 0xC5 (IDE auxiliary base) is masked with 0xFC and then has bit 1 set to 1. Its base output is the register shifted left by two.
- R7: The IRQ and DMA numbers are packed as nibbles:
  - floppy DMA = 0xC9[7:4];
  - floppy IRQ = 0xCA[7:4], parallel IRQ = 0xCA[3:0];
  - serial 1 IRQ = 0xCB[7:4], serial 2 IRQ = 0xCB[3:0].
- R8: `drive_swap` equals bit 0 of 0xD6.
- R9: Registers 0xCF and 0xD1 store the written value ANDed with 0x3F, 0xD0 with 0xFC and 0xD3 with 0x7C. Registers 0xCD, 0xCE and 0xD5 to 0xD8 store the written value unmasked.
- R10: A data-port read returns the indexed register whatever the lock state. Register 0xC0 is read-only. Unimplemented indexes read 0x00. An index-port read returns the current index.
- R11: After an accepted data-port write, the register and every output derived from it change in the following cycle. A read gives `rsp_valid` and `rsp_data` in the cycle after it is accepted. `bus_ready` stays high.
- R12: An access to any address other than the two ports changes nothing and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted; high in every cycle after reset |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | I/O address of the request |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, high for one cycle |
| rsp_data | output | 8 | Read response data |
| en_game | output | 1 | Game port enable |
| en_ide | output | 1 | IDE enable |
| en_fdc | output | 1 | Floppy enable |
| en_ser1 | output | 1 | Serial 1 enable |
| en_ser2 | output | 1 | Serial 2 enable |
| en_par | output | 1 | Parallel enable |
| par_mode | output | 2 | Parallel mode field |
| fdc_base | output | 10 | Floppy base address |
| fdc_irq | output | 4 | Floppy IRQ |
| fdc_dma | output | 4 | Floppy DMA channel |
| drive_swap | output | 1 | Floppy drive swap |
| ide_base | output | 10 | IDE base address |
| ide_aux_base | output | 10 | IDE auxiliary base address |
| par_base | output | 10 | Parallel base address |
| par_irq | output | 4 | Parallel IRQ |
| ser1_base | output | 10 | Serial 1 base address |
| ser1_irq | output | 4 | Serial 1 IRQ |
| ser2_base | output | 10 | Serial 2 base address |
| ser2_irq | output | 4 | Serial 2 IRQ |

## Verification
The bench targets several corner cases, each tied to a specific design fault:
- A data write while locked must be ignored; a design that ignored the lock would show the new value on the decoded outputs.
- Writing a lock key must update the index as well as the lock; a design that did not would read back the wrong register afterwards.
- A write to the IDE auxiliary base must come back with bit 1 forced; a design that dropped the force would return the raw masked value.
- Function-select bit 6 must always read 0.
- Every non-zero parallel mode must clear `en_par`; a design that checked only one mode bit would leave the parallel port enabled in one of those modes.
- The read-only index 0xC0, the unimplemented gaps between registers, and addresses just outside the two ports each expose faulty address decoding.

A seeded random mix of keys, indexes and data runs the per-register masks against a bench model.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam logic [7:0] FIRST_IDX = 8'hC0;
  localparam logic [7:0] LAST_IDX  = 8'hD8;
  localparam int NREG = int'(LAST_IDX) - int'(FIRST_IDX) + 1;

  localparam logic [7:0] IX_ID   = 8'hC0;
  localparam logic [7:0] IX_FSEL = 8'hC2;
  localparam logic [7:0] IX_BFDC = 8'hC3;
  localparam logic [7:0] IX_BIDE = 8'hC4;
  localparam logic [7:0] IX_BAUX = 8'hC5;
  localparam logic [7:0] IX_BPAR = 8'hC6;
  localparam logic [7:0] IX_BS1  = 8'hC7;
  localparam logic [7:0] IX_BS2  = 8'hC8;
  localparam logic [7:0] IX_DMA  = 8'hC9;
  localparam logic [7:0] IX_IRQP = 8'hCA;
  localparam logic [7:0] IX_IRQS = 8'hCB;
  localparam logic [7:0] IX_MISC = 8'hD6;

  // Write mask per index; zero means not writable.
  function automatic logic [7:0] wr_mask(input logic [7:0] ix);
    case (ix)
      IX_FSEL:                   return 8'hBF;
      IX_BFDC, IX_BIDE, IX_BAUX: return 8'hFC;
      IX_BS1, IX_BS2:            return 8'hFE;
      8'hCF, 8'hD1:              return 8'h3F;
      8'hD0:                     return 8'hFC;
      8'hD3:                     return 8'h7C;
      IX_BPAR, IX_DMA, IX_IRQP, IX_IRQS,
      8'hCD, 8'hCE, 8'hD5, IX_MISC, 8'hD7, 8'hD8: return 8'hFF;
      default:                   return 8'h00;
    endcase
  endfunction

  // Bits forced high on every write.
  function automatic logic [7:0] wr_force(input logic [7:0] ix);
    return (ix == IX_BAUX) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic [7:0] rst_val(input logic [7:0] ix);
    case (ix)
      IX_ID, IX_BFDC, IX_BIDE, 8'hD5: return 8'h3C;
      IX_FSEL:                        return 8'h03;
      IX_BAUX:                        return 8'h3D;
      default:                        return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgx_port_dec.sv
module cfgx_port_dec #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] IDX_PORT   = 16'h0398,
  parameter logic [7:0]  UNLOCK_KEY = 8'h33,
  parameter logic [7:0]  LOCK_KEY   = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        idx_q,
  output logic              unlocked_q,
  output logic              wr_en,
  output logic              rd_req,
  output logic              rd_from_idx
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(IDX_PORT + 16'd1);

  logic hit_idx, hit_dat;
  assign hit_idx     = bus_valid && (bus_addr == IDX_A);
  assign hit_dat     = bus_valid && (bus_addr == DAT_A);
  assign wr_en       = hit_dat && bus_write && unlocked_q;
  assign rd_req      = (hit_idx || hit_dat) && !bus_write;
  assign rd_from_idx = hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= 8'h00;
      unlocked_q <= 1'b0;
    end else if (hit_idx && bus_write) begin
      idx_q <= bus_wdata;
      if (bus_wdata == UNLOCK_KEY)    unlocked_q <= 1'b1;
      else if (bus_wdata == LOCK_KEY) unlocked_q <= 1'b0;
    end
  end

  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_idx && bus_write && bus_wdata == UNLOCK_KEY) |=> unlocked_q);
  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_idx && bus_write && bus_wdata == LOCK_KEY) |=> !unlocked_q);
endmodule

// File: rtl/cfgx_regfile.sv
module cfgx_regfile
  import cfgx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] fsel_o,
  output logic [7:0] bfdc_o,
  output logic [7:0] bide_o,
  output logic [7:0] baux_o,
  output logic [7:0] bpar_o,
  output logic [7:0] bs1_o,
  output logic [7:0] bs2_o,
  output logic [7:0] dma_o,
  output logic [7:0] irqp_o,
  output logic [7:0] irqs_o,
  output logic [7:0] misc_o
);
  localparam int OFF_W = $clog2(NREG);

  logic [NREG-1:0][7:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] IX = 8'(int'(FIRST_IDX) + i);
    localparam logic [7:0] MK = wr_mask(IX);
    localparam logic [7:0] FC = wr_force(IX);
    localparam logic [7:0] RV = rst_val(IX);
    if (MK != 8'h00) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= RV;
        else if (wr_en && wr_idx == IX) regs[i] <= (wr_data & MK) | FC;
      end
    end else begin : g_ro
      assign regs[i] = RV;
    end
  end

  logic [7:0] rd_off;
  logic       in_rng;
  assign rd_off  = rd_idx - FIRST_IDX;
  assign in_rng  = (rd_idx >= FIRST_IDX) && (rd_idx <= LAST_IDX);
  assign rd_data = in_rng ? regs[rd_off[OFF_W-1:0]] : 8'h00;

  logic [7:0] unused_off;
  assign unused_off = rd_off;

  assign fsel_o = regs[int'(IX_FSEL - FIRST_IDX)];
  assign bfdc_o = regs[int'(IX_BFDC - FIRST_IDX)];
  assign bide_o = regs[int'(IX_BIDE - FIRST_IDX)];
  assign baux_o = regs[int'(IX_BAUX - FIRST_IDX)];
  assign bpar_o = regs[int'(IX_BPAR - FIRST_IDX)];
  assign bs1_o  = regs[int'(IX_BS1  - FIRST_IDX)];
  assign bs2_o  = regs[int'(IX_BS2  - FIRST_IDX)];
  assign dma_o  = regs[int'(IX_DMA  - FIRST_IDX)];
  assign irqp_o = regs[int'(IX_IRQP - FIRST_IDX)];
  assign irqs_o = regs[int'(IX_IRQS - FIRST_IDX)];
  assign misc_o = regs[int'(IX_MISC - FIRST_IDX)];

  // R2: without an accepted write no register moves
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
  // R3: bit 6 of function select never stored
  p_fsel_b6_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_o[6] == 1'b0);
endmodule

// File: rtl/cfgx_resolve.sv
module cfgx_resolve #(
  parameter int BASE_W = 10,
  parameter int NUM_W  = 4
) (
  input  logic [7:0]        fsel_i,
  input  logic [7:0]        bfdc_i,
  input  logic [7:0]        bide_i,
  input  logic [7:0]        baux_i,
  input  logic [7:0]        bpar_i,
  input  logic [7:0]        bs1_i,
  input  logic [7:0]        bs2_i,
  input  logic [7:0]        dma_i,
  input  logic [7:0]        irqp_i,
  input  logic [7:0]        irqs_i,
  input  logic [7:0]        misc_i,
  output logic              en_game,
  output logic              en_ide,
  output logic              en_fdc,
  output logic              en_ser1,
  output logic              en_ser2,
  output logic              en_par,
  output logic [1:0]        par_mode,
  output logic [BASE_W-1:0] fdc_base,
  output logic [BASE_W-1:0] ide_base,
  output logic [BASE_W-1:0] ide_aux_base,
  output logic [BASE_W-1:0] par_base,
  output logic [BASE_W-1:0] ser1_base,
  output logic [BASE_W-1:0] ser2_base,
  output logic [NUM_W-1:0]  fdc_irq,
  output logic [NUM_W-1:0]  fdc_dma,
  output logic [NUM_W-1:0]  par_irq,
  output logic [NUM_W-1:0]  ser1_irq,
  output logic [NUM_W-1:0]  ser2_irq,
  output logic              drive_swap
);
  localparam int SH = BASE_W - 8;

  function automatic logic [BASE_W-1:0] widen(input logic [7:0] r);
    return {r, {SH{1'b0}}};
  endfunction

  assign en_game  = fsel_i[7];
  assign en_ide   = fsel_i[5];
  assign en_fdc   = fsel_i[4];
  assign en_ser2  = fsel_i[3];
  assign en_ser1  = fsel_i[2];
  assign par_mode = fsel_i[1:0];
  assign en_par   = (fsel_i[1:0] == 2'b00);

  assign fdc_base     = widen(bfdc_i);
  assign ide_base     = widen(bide_i);
  assign ide_aux_base = widen(baux_i);
  assign par_base     = widen(bpar_i);
  assign ser1_base    = widen(bs1_i);
  assign ser2_base    = widen(bs2_i);

  assign fdc_dma  = dma_i[7:8-NUM_W];
  assign fdc_irq  = irqp_i[7:8-NUM_W];
  assign par_irq  = irqp_i[NUM_W-1:0];
  assign ser1_irq = irqs_i[7:8-NUM_W];
  assign ser2_irq = irqs_i[NUM_W-1:0];
  assign drive_swap = misc_i[0];

  logic unused_bits;
  assign unused_bits = ^{fsel_i[6], dma_i[3:0], misc_i[7:1]};
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] IDX_PORT   = 16'h0398,
  parameter logic [7:0]  UNLOCK_KEY = 8'h33,
  parameter logic [7:0]  LOCK_KEY   = 8'h55,
  parameter int          BASE_W     = 10,
  parameter int          NUM_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              en_game,
  output logic              en_ide,
  output logic              en_fdc,
  output logic              en_ser1,
  output logic              en_ser2,
  output logic              en_par,
  output logic [1:0]        par_mode,
  output logic [BASE_W-1:0] fdc_base,
  output logic [NUM_W-1:0]  fdc_irq,
  output logic [NUM_W-1:0]  fdc_dma,
  output logic              drive_swap,
  output logic [BASE_W-1:0] ide_base,
  output logic [BASE_W-1:0] ide_aux_base,
  output logic [BASE_W-1:0] par_base,
  output logic [NUM_W-1:0]  par_irq,
  output logic [BASE_W-1:0] ser1_base,
  output logic [NUM_W-1:0]  ser1_irq,
  output logic [BASE_W-1:0] ser2_base,
  output logic [NUM_W-1:0]  ser2_irq
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(IDX_PORT + 16'd1);

  logic [7:0] idx_q, rd_data;
  logic       unlocked_q, wr_en, rd_req, rd_from_idx;
  logic [7:0] fsel, bfdc, bide, baux, bpar, bs1, bs2, dma, irqp, irqs, misc;

  assign bus_ready = rst_n;

  cfgx_port_dec #(.ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT),
                  .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .idx_q(idx_q),
    .unlocked_q(unlocked_q), .wr_en(wr_en), .rd_req(rd_req),
    .rd_from_idx(rd_from_idx));

  cfgx_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx_q),
    .wr_data(bus_wdata), .rd_idx(idx_q), .rd_data(rd_data),
    .fsel_o(fsel), .bfdc_o(bfdc), .bide_o(bide), .baux_o(baux),
    .bpar_o(bpar), .bs1_o(bs1), .bs2_o(bs2), .dma_o(dma),
    .irqp_o(irqp), .irqs_o(irqs), .misc_o(misc));

  cfgx_resolve #(.BASE_W(BASE_W), .NUM_W(NUM_W)) u_res (
    .fsel_i(fsel), .bfdc_i(bfdc), .bide_i(bide), .baux_i(baux),
    .bpar_i(bpar), .bs1_i(bs1), .bs2_i(bs2), .dma_i(dma),
    .irqp_i(irqp), .irqs_i(irqs), .misc_i(misc),
    .en_game(en_game), .en_ide(en_ide), .en_fdc(en_fdc),
    .en_ser1(en_ser1), .en_ser2(en_ser2), .en_par(en_par),
    .par_mode(par_mode), .fdc_base(fdc_base), .ide_base(ide_base),
    .ide_aux_base(ide_aux_base), .par_base(par_base),
    .ser1_base(ser1_base), .ser2_base(ser2_base), .fdc_irq(fdc_irq),
    .fdc_dma(fdc_dma), .par_irq(par_irq), .ser1_irq(ser1_irq),
    .ser2_irq(ser2_irq), .drive_swap(drive_swap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_from_idx ? idx_q : rd_data;
    end
  end

  logic port_rd;
  assign port_rd = bus_valid && !bus_write &&
                   (bus_addr == IDX_A || bus_addr == DAT_A);

  p_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> rsp_valid);
  p_no_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !port_rd |=> !rsp_valid);
  p_aux_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == DAT_A && unlocked_q &&
     idx_q == 8'hC5) |=> ide_aux_base[3]);
  p_fdc_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_base[3:2] == 2'b00);
endmodule

// File: tb/cfgx_top_tb.sv
module cfgx_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic bus_ready, rsp_valid, en_game, en_ide, en_fdc, en_ser1, en_ser2, en_par, drive_swap;
  logic [7:0] rsp_data;
  logic [1:0] par_mode;
  logic [9:0] fdc_base, ide_base, ide_aux_base, par_base, ser1_base, ser2_base;
  logic [3:0] fdc_irq, fdc_dma, par_irq, ser1_irq, ser2_irq;

  int total = 0, bad = 0;
  logic [7:0] m_reg [256];
  logic [7:0] m_idx;
  logic       m_unl;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_top dut_i (.*);

  function automatic logic [7:0] e_mask(input logic [7:0] ix);
    case (ix)
      8'hC2: return 8'hBF;
      8'hC3, 8'hC4, 8'hC5, 8'hD0: return 8'hFC;
      8'hC7, 8'hC8: return 8'hFE;
      8'hCF, 8'hD1: return 8'h3F;
      8'hD3: return 8'h7C;
      8'hC6, 8'hC9, 8'hCA, 8'hCB, 8'hCD, 8'hCE,
      8'hD5, 8'hD6, 8'hD7, 8'hD8: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
    m_reg[8'hC0] = 8'h3C; m_reg[8'hC2] = 8'h03; m_reg[8'hC3] = 8'h3C;
    m_reg[8'hC4] = 8'h3C; m_reg[8'hC5] = 8'h3D; m_reg[8'hD5] = 8'h3C;
    m_idx = 8'h00; m_unl = 1'b0;
  endtask

  task automatic check_outs();
    logic [7:0] f;
    f = m_reg[8'hC2];
    chk("R3 enables", {en_game, en_ide, en_fdc, en_ser2, en_ser1},
        {f[7], f[5], f[4], f[3], f[2]});
    chk("R4 par", {en_par, par_mode}, {(f[1:0] == 2'b00), f[1:0]});
    chk("R5 bases", {fdc_base, ide_base, par_base, ser1_base, ser2_base},
        {m_reg[8'hC3], 2'b0, m_reg[8'hC4], 2'b0, m_reg[8'hC6], 2'b0,
         m_reg[8'hC7], 2'b0, m_reg[8'hC8], 2'b0});
    chk("R6 aux base", ide_aux_base, {m_reg[8'hC5], 2'b0});
    chk("R7 irq dma", {fdc_dma, fdc_irq, par_irq, ser1_irq, ser2_irq},
        {m_reg[8'hC9][7:4], m_reg[8'hCA], m_reg[8'hCB]});
    chk("R8 swap", drive_swap, m_reg[8'hD6][0]);
    chk("R11 ready", bus_ready, 1);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    if (a == 16'h0398) begin
      m_idx = d;
      if (d == 8'h33) m_unl = 1'b1;
      else if (d == 8'h55) m_unl = 1'b0;
    end else if (a == 16'h0399 && m_unl && e_mask(m_idx) != 8'h00) begin
      m_reg[m_idx] = (d & e_mask(m_idx)) | ((m_idx == 8'hC5) ? 8'h02 : 8'h00);
    end
    @(negedge clk);
    chk("R12 no rsp on write", rsp_valid, 0);
    check_outs();
  endtask

  task automatic bus_rd(input logic [15:0] a, input string tag);
    logic hit;
    hit = (a == 16'h0398) || (a == 16'h0399);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R11 rsp_valid"}, rsp_valid, hit);
    if (a == 16'h0398) chk({tag, " R10 index read"}, rsp_data, m_idx);
    else if (hit) chk({tag, " R10 data read"}, rsp_data, m_reg[m_idx]);
  endtask

  task automatic rd_reg(input logic [7:0] ix, input string tag);
    bus_wr(16'h0398, ix);
    bus_rd(16'h0399, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0007);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_outs();
    chk("R1 en_par off at reset", en_par, 0);
    rd_reg(8'hC0, "R1 id");
    rd_reg(8'hC5, "R1 aux");
    rd_reg(8'hD5, "R1 d5");
    rd_reg(8'hCB, "R1 cb");
    // R2: locked write ignored
    bus_wr(16'h0398, 8'hC3);
    bus_wr(16'h0399, 8'h00);
    chk("R2 locked write", fdc_base, 10'h0F0);
    // R2: unlock, write, then lock key becomes index
    bus_wr(16'h0398, 8'h33);
    bus_wr(16'h0398, 8'hC2);
    bus_wr(16'h0399, 8'hFF);
    chk("R3 fsel all", {en_game, en_ide, en_fdc, en_ser2, en_ser1}, 5'h1F);
    bus_rd(16'h0399, "R3 bit6 masked");
    bus_wr(16'h0399, 8'h01);
    chk("R4 ECP disables par", en_par, 0);
    bus_wr(16'h0399, 8'h02);
    chk("R4 EPP disables par", en_par, 0);
    bus_wr(16'h0399, 8'h00);
    chk("R4 standard enables par", en_par, 1);
    // R6
    bus_wr(16'h0398, 8'hC5);
    bus_wr(16'h0399, 8'h00);
    chk("R6 aux forced", ide_aux_base, 10'h008);
    bus_rd(16'h0399, "R6 aux read");
    // R9 masks and read-only C0
    rd_reg(8'hCF, "R9 cf pre");
    bus_wr(16'h0399, 8'hFF); bus_rd(16'h0399, "R9 cf");
    bus_wr(16'h0398, 8'hD3); bus_wr(16'h0399, 8'hFF); bus_rd(16'h0399, "R9 d3");
    bus_wr(16'h0398, 8'hC0); bus_wr(16'h0399, 8'h00); bus_rd(16'h0399, "R10 c0 ro");
    bus_wr(16'h0398, 8'hCC); bus_wr(16'h0399, 8'hAA); bus_rd(16'h0399, "R10 gap");
    // R12: neighbouring addresses
    bus_wr(16'h0397, 8'hC3); bus_wr(16'h039A, 8'h11);
    bus_rd(16'h039A, "R12 off-port read");
    bus_rd(16'h0398, "R12 index kept");
    // R2: lock key, then read still works (R10)
    bus_wr(16'h0398, 8'h55);
    bus_rd(16'h0398, "R2 lock key index");
    bus_wr(16'h0398, 8'hC9);
    bus_wr(16'h0399, 8'h70);
    bus_rd(16'h0399, "R10 read while locked");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [7:0] v;
      sel = int'($urandom_range(0, 9));
      v = 8'($urandom);
      case (sel)
        0: bus_wr(16'h0398, ($urandom_range(0, 3) == 0) ? 8'h55 : 8'h33);
        1, 2: bus_wr(16'h0398, 8'(8'hBE + $urandom_range(0, 28)));
        3, 4, 5: bus_wr(16'h0399, v);
        6, 7: bus_rd(16'h0399, "R10 rand");
        8: bus_rd(16'h0398, "R10 rand idx");
        default: bus_wr(($urandom_range(0, 1) == 0) ? 16'h0390 : 16'h0799, v);
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule